// File: doc/BRIEF.md
# Vertical Blank Interrupt Controller

This block is the interrupt unit of a display controller. It has two software-visible words: a status word that records pending events and an enable word that selects which pending events may interrupt. Both are reached through a minimal register bus with one select bit, a write strobe, write data and a combinational read path. The only event source is the frame tick. A built-in counter stands in for display timing and produces one vertical-blank event every `TICK_CYCLES` clocks. That is about 60 Hz at the default clock.

Software acknowledges events by writing ones to the status word. Only the bits that a per-variant clearable mask allows are cleared. The variant is chosen by a parameter. Turning the vertical-blank enable on marks an event straight away and restarts the frame counter. Turning it off halts the counter. The level interrupt output is high whenever an enabled status bit is pending.

Top module: `vbi_top`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, the status word, the enable word and `irq_o` are all zero. No frame event follows a reset until the vertical-blank enable is written again.
- R2: `irq_o` is high exactly when some bit is set in both the status word and the enable word.
- R3: A write to the enable word (`bus_sel_i`=1) with bit 0 set makes status bit 0 read 1 from the next cycle on.
- R4: Once the enable word is written with bit 0 set, status bit 0 is set again every `TICK_CYCLES` clocks. The first set is `TICK_CYCLES` edges after the write edge. Each such write restarts this count.
- R5: A write to the enable word with bit 0 clear stops frame events at once. Status bit 0 keeps its value.
- R6: A write to the status word (`bus_sel_i`=0) clears each status bit whose written bit and clearable-mask bit are both 1. The mask is 0x000F040F when `VARIANT`=0 and 0xFC080EFF when `VARIANT`=1. Bit 0 is clearable in both.
- R7: When a frame event and a clear of status bit 0 fall in the same cycle, status bit 0 ends up set.
- R8: Status bits 31..1 have no source and always read 0, whatever is written to either word.
- R9: `bus_rdata_o` shows the status word when `bus_sel_i`=0 and the enable word when `bus_sel_i`=1. The enable word stores all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe for the selected word |
| bus_sel_i | input | 1 | Word select: 0 status, 1 enable |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the selected word |
| irq_o | output | 1 | Level interrupt request |

## Verification
The checker watches several rules on every cycle. An idle enable word keeps `irq_o` low. An enable write with bit 0 set, or a frame tick, leaves status bit 0 set on the next edge, and this covers the case where a clear arrives in the same cycle. A clear write outside a tick leaves the bit clear. The unsourced status bits stay zero, and no tick happens while the enable is off. The exact period and the restart of the count on each enable write can only be shown by the bench's timed scenarios. The same holds for readback of the full enable word and for the mask sweep over every bit position.

// File: rtl/vbi_pkg.sv
package vbi_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned VB_BIT = 0;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_ENABLE = 1'b1
  } reg_sel_e;

  function automatic logic [WORD_W-1:0] clear_mask(input logic variant);
    return variant ? 32'hFC08_0EFF : 32'h000F_040F;
  endfunction
endpackage

// File: rtl/vbi_frame_tick.sv
module vbi_frame_tick #(
  parameter int unsigned PERIOD = 1_666_667
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic stop_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last = (cnt_q == LAST);
  // a write to the enable word overrides any tick in flight
  assign tick_o  = run_i && at_last && !restart_i && !stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (restart_i || stop_i)    cnt_q <= '0;
    else if (!run_i || at_last)      cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/vbi_status_reg.sv
module vbi_status_reg #(
  parameter int unsigned W       = 32,
  parameter logic [W-1:0] SRC_MASK = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (SRC_MASK[i]) begin : g_src
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q <= 1'b0;
        else if (set_i[i]) q <= 1'b1;   // set beats clear
        else if (clr_i[i]) q <= 1'b0;
      end
      assign status_o[i] = q;
    end else begin : g_nosrc
      logic unused_set;
      assign unused_set  = set_i[i];
      assign status_o[i] = 1'b0;
    end
  end

  logic unused_clr;
  assign unused_clr = ^(clr_i & ~SRC_MASK);
endmodule

// File: rtl/vbi_top.sv
module vbi_top
  import vbi_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 1_666_667,
  parameter logic        VARIANT     = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic              bus_sel_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  localparam logic [WORD_W-1:0] CLR_MASK = clear_mask(VARIANT);
  localparam logic [WORD_W-1:0] VB_MASK  = WORD_W'(1) << VB_BIT;

  logic [WORD_W-1:0] en_q;
  logic [WORD_W-1:0] status_q;
  logic [WORD_W-1:0] set_vec;
  logic [WORD_W-1:0] clr_vec;
  logic              en_wr, st_wr, vb_on_wr, vb_off_wr, vb_tick;

  assign en_wr     = bus_we_i && (reg_sel_e'(bus_sel_i) == SEL_ENABLE);
  assign st_wr     = bus_we_i && (reg_sel_e'(bus_sel_i) == SEL_STATUS);
  assign vb_on_wr  = en_wr &&  bus_wdata_i[VB_BIT];
  assign vb_off_wr = en_wr && !bus_wdata_i[VB_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= '0;
    else if (en_wr) en_q <= bus_wdata_i;
  end

  vbi_frame_tick #(.PERIOD(TICK_CYCLES)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (vb_on_wr),
    .stop_i    (vb_off_wr),
    .run_i     (en_q[VB_BIT]),
    .tick_o    (vb_tick)
  );

  assign set_vec = (vb_on_wr || vb_tick) ? VB_MASK : '0;
  assign clr_vec = st_wr ? (bus_wdata_i & CLR_MASK) : '0;

  vbi_status_reg #(.W(WORD_W), .SRC_MASK(VB_MASK)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_vec),
    .clr_i    (clr_vec),
    .status_o (status_q)
  );

  assign bus_rdata_o = (reg_sel_e'(bus_sel_i) == SEL_ENABLE) ? en_q : status_q;
  assign irq_o       = |(status_q & en_q);
endmodule

// File: rtl/vbi_checker.sv
module vbi_checker #(
  parameter int unsigned W  = 32,
  parameter int unsigned VB = 0
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         bus_we_i,
  input logic         bus_sel_i,
  input logic         wr_vb,
  input logic         irq_o,
  input logic [W-1:0] status_q,
  input logic [W-1:0] en_q,
  input logic         vb_tick
);
  // R2
  p_idle_enable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !irq_o);

  // R3
  p_enable_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_sel_i && wr_vb) |=> status_q[VB]);

  // R7
  p_tick_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vb_tick |=> status_q[VB]);

  // R6
  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && !bus_sel_i && wr_vb && !vb_tick) |=> !status_q[VB]);

  // R5
  p_no_tick_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q[VB] |-> !vb_tick);

  // R8
  p_nosrc_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(status_q) <= 1 && (status_q[VB] || status_q == '0));
endmodule

bind vbi_top vbi_checker #(.W(vbi_pkg::WORD_W), .VB(vbi_pkg::VB_BIT)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .bus_we_i (bus_we_i),
  .bus_sel_i(bus_sel_i),
  .wr_vb    (bus_wdata_i[vbi_pkg::VB_BIT]),
  .irq_o    (irq_o),
  .status_q (status_q),
  .en_q     (en_q),
  .vb_tick  (vb_tick)
);

// File: tb/tb_vbi_top.sv
`timescale 1ns/1ps
module tb_vbi_top;
  localparam int unsigned P    = 8;
  localparam logic [31:0] MASK = 32'hFC08_0EFF;   // VARIANT=1

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic        sel = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  vbi_top #(.TICK_CYCLES(P), .VARIANT(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_sel_i(sel),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge; returns at the negedge after the write edge
  task automatic wr(input logic s, input logic [31:0] d);
    we = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic s, output logic [31:0] v);
    sel = s; #0.5; v = rdata;
  endtask

  // enable at edge E0, clear at E1, status bit 0 must return at E0+P only
  task automatic period_run(input string req);
    logic [31:0] v;
    wr(1'b1, 32'h1);
    rd(1'b0, v); chk("R3", v, 32'h1);
    wr(1'b0, 32'h1);
    for (int k = 2; k <= int'(P); k++) begin
      @(negedge clk);
      rd(1'b0, v); chk(req, v, (k == int'(P)) ? 32'h1 : 32'h0);
      chk("R2", {31'b0, irq}, (k == int'(P)) ? 32'h1 : 32'h0);
    end
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rd(1'b0, v); chk("R1", v, 0);
    rd(1'b1, v); chk("R1", v, 0);
    chk("R1", {31'b0, irq}, 0);
    rst_n = 1'b1;
    repeat (2*P) @(negedge clk);
    rd(1'b0, v); chk("R1", v, 0);

    period_run("R4");
    // set wins: clear at E_{P+1}, then clear again on the tick edge
    wr(1'b0, 32'h1);
    repeat (P-2) @(negedge clk);
    rd(1'b0, v); chk("R4", v, 0);
    wr(1'b0, 32'h1);
    rd(1'b0, v); chk("R7", v, 32'h1);

    // restart mid-period
    repeat (3) @(negedge clk);
    period_run("R4");

    // disable: status held, irq low, no more events
    wr(1'b1, 32'hFFFF_FFFE);
    rd(1'b0, v); chk("R5", v, 32'h1);
    rd(1'b1, v); chk("R9", v, 32'hFFFF_FFFE);
    chk("R2", {31'b0, irq}, 0);
    wr(1'b0, 32'h1);
    for (int k = 0; k < int'(3*P); k++) begin
      @(negedge clk);
      rd(1'b0, v); chk("R5", v, 0);
    end

    // clear-mask sweep over every bit position
    for (int i = 0; i < 32; i++) begin
      wr(1'b1, 32'h1);
      wr(1'b0, 32'h1 << i);
      rd(1'b0, v);
      chk("R6", v, 32'h1 & ~((32'h1 << i) & MASK));
    end
    wr(1'b1, 32'h1);
    wr(1'b0, 32'hFFFF_FFFE);
    rd(1'b0, v); chk("R8", v, 32'h1);

    // enable sweep: readback and irq gating
    for (int i = 0; i < 32; i++) begin
      wr(1'b1, 32'h0);
      wr(1'b0, 32'h1);
      wr(1'b1, 32'h1 << i);
      rd(1'b1, v); chk("R9", v, 32'h1 << i);
      rd(1'b0, v); chk("R3", v, (i == 0) ? 32'h1 : 32'h0);
      chk("R2", {31'b0, irq}, (i == 0) ? 32'h1 : 32'h0);
      if (i != 0) begin
        wr(1'b1, 32'h1);
        wr(1'b1, 32'h1 << i);
        chk("R2", {31'b0, irq}, 0);
        rd(1'b0, v); chk("R8", v, 32'h1);
      end
    end

    // reset mid-run
    wr(1'b1, 32'hFFFF_FFFF);
    #1 rst_n = 1'b0;
    #1;
    rd(1'b0, v); chk("R1", v, 0);
    rd(1'b1, v); chk("R1", v, 0);
    chk("R1", {31'b0, irq}, 0);
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < int'(2*P); k++) begin
      @(negedge clk);
      rd(1'b0, v); chk("R1", v, 0);
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule